// File: doc/BRIEF.md
# Predicated prefetch address sequencer

This block takes one contiguous doubleword prefetch command and turns it into a series of prefetch hint requests, one for each active vector element. A command carries a 64-bit base value, a 64-bit element index, a byte-granular predicate, the vector length in bits, a 4-bit operation code and the numbers of the base and offset registers it names. The element size is fixed at 64 bits. Element e is prefetched from base + ((index + e) << 3), wrapping modulo 2^64. The index is only read and is never written back.

Each request carries the address, a write-hint bit, a two-bit cache level, a streaming bit and a flag saying that the base came from the stack pointer. Requests leave over a valid/ready handshake, in ascending element order, at most one per cycle. When the command has finished, a one-cycle completion pulse follows. A command that uses a reserved operation code or an offset register number of 31 issues no requests and is reported through an undefined flag, which is raised together with the completion pulse.

Top module: `pfetch_seq`

## Requirements
- R1: The request address for element e equals cmdBase + ((cmdIndex + e) << 3), taken modulo 2^64.
- R2: Element e (0 <= e < cmdVlen/64) is active only when cmdPred bit 8*e is set. All other predicate bits, and elements at or beyond cmdVlen/64, produce no request.
- R3: Active elements are requested in ascending element order, and a request is consumed in each cycle in which reqValid and reqReady are both high.
- R4: A command with no active element issues no request, and done is raised in the cycle after the command is accepted.
- R5: reqWrite equals bit 3 of the operation code (0 means read prefetch, 1 means write prefetch).
- R6: reqLevel equals operation code bits 2:1 (00 = L1, 01 = L2, 10 = L3). reqStream equals bit 0 (1 means streaming, 0 means keep).
- R7: An operation code with bits 2:1 equal to 11 issues no request, and raises undef together with done for one cycle in the cycle after acceptance.
- R8: An offset register number of 31 makes the command undefined in the same way as R7, whatever the predicate holds.
- R9: reqFromSp is 1 on every request of a command whose base register number is 31, and 0 otherwise.
- R10: While reqValid is high and reqReady is low, reqValid stays high and the address and hint fields hold their values.
- R11: cmdReady is high only when the block is idle, and cmdValid is ignored while a command is in progress. Done pulses for exactly one cycle after the last active request has been accepted, and the block is then idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle and able to take a command |
| cmdBase | input | 64 | Base address value |
| cmdIndex | input | 64 | Starting element index |
| cmdPred | input | 256 | Byte-granular predicate (bit 8*e governs element e) |
| cmdVlen | input | 12 | Vector length in bits (multiple of 128, 128 to 2048) |
| cmdOp | input | 4 | Prefetch operation code |
| cmdBaseReg | input | 5 | Base register number (31 selects stack pointer) |
| cmdOffReg | input | 5 | Offset register number (31 is undefined) |
| reqValid | output | 1 | Prefetch request valid |
| reqReady | input | 1 | Prefetch request accepted |
| reqAddr | output | 64 | Prefetch address |
| reqWrite | output | 1 | Write hint (1) or read hint (0) |
| reqLevel | output | 2 | Target cache level |
| reqStream | output | 1 | Streaming (1) or keep (0) |
| reqFromSp | output | 1 | Base taken from the stack pointer |
| done | output | 1 | One-cycle command completion pulse |
| undef | output | 1 | Command undefined; raised with done |

## Verification
Two events can coincide at the command boundary. A new cmdValid can arrive while the last request is still being consumed or while done is pulsing, and the undefined flag is raised in the same cycle as completion. The bench holds cmdValid high with a different command for the whole run of a stalled command. It then checks that every request still follows the first command and that done arrives only after the last handshake. For reserved codes and offset register 31, it checks that undef and done rise together one cycle after acceptance, with reqValid low throughout.

// File: rtl/pfseq_pkg.sv
package pfseq_pkg;
  typedef struct packed {
    logic load;     // capture the offered command
    logic advance;  // current element consumed, retire it
  } ctrlStrobes_t;
endpackage

// File: rtl/pfseq_ctrl.sv
module pfseq_ctrl
  import pfseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdValid,
  input  logic         cmdIsUndef,
  input  logic         maskEmpty,
  input  logic         reqReady,
  output ctrlStrobes_t strobes,
  output logic         cmdReady,
  output logic         reqValid,
  output logic         done,
  output logic         undef
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;
  logic   undefReg;

  assign cmdReady        = (state == ST_IDLE);
  assign strobes.load    = cmdReady && cmdValid;
  assign reqValid        = (state == ST_RUN) && !maskEmpty;
  assign strobes.advance = reqValid && reqReady;
  assign done            = (state == ST_RUN) && maskEmpty;
  assign undef           = done && undefReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      undefReg <= 1'b0;
    end else begin
      if (strobes.load) begin
        state    <= ST_RUN;
        undefReg <= cmdIsUndef;
      end else if (done) begin
        state <= ST_IDLE;
      end
    end
  end

  // R7: undefined flag never appears without the completion pulse
  a_r7_undef_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done && !reqValid);

  // R11: done is a single-cycle pulse followed by idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmdReady);

  // R11: no request while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmdReady |-> !reqValid && !done);
endmodule

// File: rtl/pfseq_dp.sv
module pfseq_dp
  import pfseq_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int MAX_VLEN = 2048,
  parameter int ELEM_W   = 64,
  parameter int SCALE    = 3,
  localparam int MAX_ELEMS = MAX_VLEN / ELEM_W,
  localparam int PRED_W    = MAX_VLEN / 8,
  localparam int VLEN_W    = $clog2(MAX_VLEN + 1),
  localparam int ELEM_SH   = $clog2(ELEM_W),
  localparam int ENUM_W    = $clog2(MAX_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdIndex,
  input  logic [PRED_W-1:0] cmdPred,
  input  logic [VLEN_W-1:0] cmdVlen,
  input  logic [3:0]        cmdOp,
  input  logic [4:0]        cmdBaseReg,
  input  logic [4:0]        cmdOffReg,
  output logic              cmdIsUndef,
  output logic              maskEmpty,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqWrite,
  output logic [1:0]        reqLevel,
  output logic              reqStream,
  output logic              reqFromSp
);
  logic [MAX_ELEMS-1:0] activeIn;
  logic [MAX_ELEMS-1:0] mask;
  logic [ADDR_W-1:0]    baseReg, idxReg;
  logic [3:0]           opReg;
  logic                 spReg;
  logic [VLEN_W-1:0]    elemCount;
  logic [ENUM_W-1:0]    elemNum;
  logic [ADDR_W-1:0]    elemOff;
  logic                 unusedPredBits;

  assign cmdIsUndef = (cmdOffReg == 5'd31) || (cmdOp[2:1] == 2'b11);
  assign elemCount  = cmdVlen >> ELEM_SH;
  assign unusedPredBits = ^cmdPred;

  for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_active
    assign activeIn[e] = cmdPred[e*8] && (VLEN_W'(e) < elemCount);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      baseReg <= '0;
      idxReg  <= '0;
      opReg   <= '0;
      spReg   <= 1'b0;
    end else if (strobes.load) begin
      mask    <= cmdIsUndef ? '0 : activeIn;
      baseReg <= cmdBase;
      idxReg  <= cmdIndex;
      opReg   <= cmdOp;
      spReg   <= (cmdBaseReg == 5'd31);
    end else if (strobes.advance) begin
      mask <= mask & (mask - 1'b1);
    end
  end

  always_comb begin
    elemNum = '0;
    for (int i = MAX_ELEMS - 1; i >= 0; i--) begin
      if (mask[i]) elemNum = ENUM_W'(i);
    end
  end

  assign maskEmpty = (mask == '0);
  assign elemOff   = idxReg + ADDR_W'(elemNum);
  assign reqAddr   = baseReg + (elemOff << SCALE);
  assign reqWrite  = opReg[3];
  assign reqLevel  = opReg[2:1];
  assign reqStream = opReg[0];
  assign reqFromSp = spReg;

  // R3: each consumed request retires exactly one element
  a_r3_one_per_advance: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.advance && !strobes.load |=> $countones(mask) == $countones($past(mask)) - 1);

  // R7: a retained command never carries a reserved level
  a_r7_no_reserved_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !maskEmpty |-> reqLevel != 2'b11);
endmodule

// File: rtl/pfetch_seq.sv
module pfetch_seq
  import pfseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdValid,
  output logic         cmdReady,
  input  logic [63:0]  cmdBase,
  input  logic [63:0]  cmdIndex,
  input  logic [255:0] cmdPred,
  input  logic [11:0]  cmdVlen,
  input  logic [3:0]   cmdOp,
  input  logic [4:0]   cmdBaseReg,
  input  logic [4:0]   cmdOffReg,
  output logic         reqValid,
  input  logic         reqReady,
  output logic [63:0]  reqAddr,
  output logic         reqWrite,
  output logic [1:0]   reqLevel,
  output logic         reqStream,
  output logic         reqFromSp,
  output logic         done,
  output logic         undef
);
  ctrlStrobes_t strobes;
  logic         cmdIsUndef;
  logic         maskEmpty;

  pfseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdIsUndef(cmdIsUndef),
    .maskEmpty(maskEmpty), .reqReady(reqReady), .strobes(strobes),
    .cmdReady(cmdReady), .reqValid(reqValid), .done(done), .undef(undef)
  );

  pfseq_dp #(.ADDR_W(64), .MAX_VLEN(2048), .ELEM_W(64), .SCALE(3)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .cmdBase(cmdBase), .cmdIndex(cmdIndex), .cmdPred(cmdPred), .cmdVlen(cmdVlen),
    .cmdOp(cmdOp), .cmdBaseReg(cmdBaseReg), .cmdOffReg(cmdOffReg),
    .cmdIsUndef(cmdIsUndef), .maskEmpty(maskEmpty), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqLevel(reqLevel), .reqStream(reqStream),
    .reqFromSp(reqFromSp)
  );

  // R10: a stalled request holds still
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqLevel)
                              && $stable(reqWrite) && $stable(reqStream));

  // R11: a command is only taken while no request is pending
  a_r11_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> !cmdReady);
endmodule

// File: tb/test_pfetch_seq.sv
module test_pfetch_seq;
  typedef struct packed {
    logic [63:0]  base;
    logic [63:0]  idx;
    logic [255:0] pred;
    logic [11:0]  vlen;
    logic [3:0]   op;
    logic [4:0]   baseReg;
    logic [4:0]   offReg;
    logic         stall;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{64'h1000, 64'h0, {32{8'h01}}, 12'd256, 4'b0000, 5'd3, 5'd4, 1'b0},
    '{64'h2000, 64'h5, 256'h0100_0100, 12'd512, 4'b1011, 5'd1, 5'd2, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 256'h0101, 12'd128, 4'b0010, 5'd7, 5'd8, 1'b0},
    '{64'h3000, 64'h1, 256'h0, 12'd1024, 4'b0000, 5'd0, 5'd1, 1'b0},
    '{64'h4000, 64'h0, {32{8'h01}}, 12'd256, 4'b0110, 5'd2, 5'd3, 1'b0},
    '{64'h5000, 64'h0, {32{8'h01}}, 12'd256, 4'b0001, 5'd2, 5'd31, 1'b0},
    '{64'h8000_0000, 64'h10, {32{8'h01}}, 12'd2048, 4'b0101, 5'd31, 5'd9, 1'b1},
    '{64'h6000, 64'h0, 256'h0001_00FE, 12'd128, 4'b1000, 5'd4, 5'd5, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [63:0] cmdBase = '0, cmdIndex = '0;
  logic [255:0] cmdPred = '0;
  logic [11:0] cmdVlen = 12'd128;
  logic [3:0] cmdOp = '0;
  logic [4:0] cmdBaseReg = '0, cmdOffReg = '0;
  logic reqValid, reqReady = 1'b0;
  logic [63:0] reqAddr;
  logic reqWrite, reqStream, reqFromSp, done, undef;
  logic [1:0] reqLevel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pfetch_seq i_pfetch_seq (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdBase(cmdBase), .cmdIndex(cmdIndex), .cmdPred(cmdPred), .cmdVlen(cmdVlen),
    .cmdOp(cmdOp), .cmdBaseReg(cmdBaseReg), .cmdOffReg(cmdOffReg),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqLevel(reqLevel), .reqStream(reqStream),
    .reqFromSp(reqFromSp), .done(done), .undef(undef)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCmd(input vec_t v, input bit holdBusy);
    int  expE[32];
    int  nExp = 0;
    int  pos = 0;
    int  cyc = 0;
    bit  isUndef;
    isUndef = (v.offReg == 5'd31) || (v.op[2:1] == 2'b11);
    if (!isUndef)
      for (int e = 0; e < int'(v.vlen) / 64; e++)
        if (v.pred[e*8]) begin expE[nExp] = e; nExp++; end
    @(negedge clk);
    check("R11 idle ready", 64'(cmdReady), 64'd1);
    cmdValid = 1'b1; cmdBase = v.base; cmdIndex = v.idx; cmdPred = v.pred;
    cmdVlen = v.vlen; cmdOp = v.op; cmdBaseReg = v.baseReg; cmdOffReg = v.offReg;
    @(negedge clk);
    if (holdBusy) begin
      cmdBase = 64'hDEAD_0000; cmdIndex = 64'h77; cmdOp = 4'b1111; cmdPred = '1;
    end else begin
      cmdValid = 1'b0;
    end
    forever begin
      if (cyc > 300) begin
        check("R11 completion timeout", 64'd0, 64'd1);
        break;
      end
      check("R11 busy not ready", 64'(cmdReady), 64'd0);
      if (pos < nExp) begin
        check("R3 request valid", 64'(reqValid), 64'd1);
        check("R1 address", reqAddr, v.base + ((v.idx + 64'(expE[pos])) << 3));
        check("R5 write hint", 64'(reqWrite), 64'(v.op[3]));
        check("R6 level", 64'(reqLevel), 64'(v.op[2:1]));
        check("R6 stream", 64'(reqStream), 64'(v.op[0]));
        check("R9 stack base", 64'(reqFromSp), 64'(v.baseReg == 5'd31));
        check("R11 no early done", 64'(done), 64'd0);
        reqReady = v.stall ? cyc[0] : 1'b1;
        @(posedge clk);
        if (reqReady) pos++;
        @(negedge clk);
        reqReady = 1'b0;
      end else begin
        check("R2 R4 no extra request", 64'(reqValid), 64'd0);
        check("R11 done pulse", 64'(done), 64'd1);
        check(isUndef ? "R7 R8 undef flag" : "R7 undef clear", 64'(undef), 64'(isUndef));
        if (nExp == 0) check("R4 R7 done latency", 64'(cyc), 64'd0);
        cmdValid = 1'b0;
        @(negedge clk);
        check("R11 done one cycle", 64'(done), 64'd0);
        check("R11 back idle", 64'(cmdReady), 64'd1);
        break;
      end
      cyc++;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset ready", 64'(cmdReady), 64'd1);
    check("R11 reset no request", 64'(reqValid), 64'd0);
    check("R11 reset no done", 64'(done), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) runCmd(VECS[i], 1'b0);
    // R11: cmdValid held with another command during a stalled run is ignored
    runCmd(VECS[1], 1'b1);
    runCmd(VECS[6], 1'b1);
    // R10: stall and check the request holds across cycles
    @(negedge clk);
    cmdValid = 1'b1; cmdBase = 64'h9000; cmdIndex = 64'h2; cmdPred = 256'h01_0000;
    cmdVlen = 12'd256; cmdOp = 4'b1100; cmdBaseReg = 5'd0; cmdOffReg = 5'd1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) begin
      check("R10 stalled valid", 64'(reqValid), 64'd1);
      check("R10 stalled address", reqAddr, 64'h9000 + (64'd4 << 3));
      check("R10 stalled level", 64'(reqLevel), 64'd2);
      @(negedge clk);
    end
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
    check("R11 done after final accept", 64'(done), 64'd1);
    @(negedge clk);
    check("R11 idle after stall test", 64'(cmdReady), 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule